// File: doc/BRIEF.md
# Shadow ROM Region Access Controller

This block decides where a host memory cycle in the top 256 KB below the 1 MB line is served. Each cycle goes either to on-board DRAM, which holds a shadow copy of expansion or system ROM, or out to the expansion bus where the ROM itself lives. A write aimed at a write-protected shadow copy can also be swallowed entirely.

Two 8-bit configuration registers control the decision. The enable register has one bit per region. The expansion area is split unevenly: one 32 KB region is followed by six 16 KB regions. The mode register holds a read-shadow bit and a write-protect bit. These two bits apply to every enabled region. They also apply to the 128 KB system BIOS area, which is always treated as enabled.

The routing flags are combinational from the current register contents and the presented access. Cycle generation toward DRAM or the bus is left to the neighbouring logic.

Top module: `shadow_route_ctrl`

## Requirements
- R1: After reset both registers read 0. Every access in C0000–DFFFF then goes to the bus. In E0000–FFFFF, reads go to the bus and writes go to DRAM.
- R2: An access below C0000 raises none of the three output flags.
- R3: The enable register is selected with `cfg_sel`=0 and the mode register with `cfg_sel`=1. Bit 0 of the enable register is reserved: it stores 0 whatever is written and always reads 0. The mode register reads back all 8 written bits.
- R4: Enable bit 1 governs the whole 32 KB range C0000–C7FFF, including both of its 16 KB halves.
- R5: Enable bit k, for k from 2 to 7, governs the 16 KB range starting at C0000 + k×4000h. Bit 2 covers C8000–CBFFF and bit 7 covers DC000–DFFFF. No bit affects another bit's range.
- R6: When a region's enable bit is 0, both reads and writes in that region raise only `to_bus`.
- R7: A read of an enabled region raises `to_dram` when mode bit 7 is 1, and `to_bus` when mode bit 7 is 0.
- R8: A write to an enabled region raises only `wr_dropped` when mode bit 6 is 1, and only `to_dram` when mode bit 6 is 0.
- R9: E0000–FFFFF has no enable bit. It behaves as an enabled region under mode bits 7 and 6, whatever the enable register holds.
- R10: A register write at one clock edge governs an access presented in the cycle right after that edge.
- R11: At most one flag is raised at a time. With `acc_valid` low, all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 enable register, 1 mode register |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read-back of the selected register |
| acc_valid | input | 1 | A host access is presented |
| acc_addr | input | 20 | Host physical address |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| to_dram | output | 1 | Serve the access from on-board DRAM |
| to_bus | output | 1 | Forward the access to the expansion bus |
| wr_dropped | output | 1 | Write discarded by write protection |

## Verification
The hardest outcome to reach is the write-drop case in a single 16 KB region. It needs a particular enable bit set, write-protect set and an address inside that one region. It must also be told apart from the neighbouring region and from the always-enabled BIOS area.

Random register values alone rarely line these up near a boundary. So the stimulus walks one enable bit at a time across all seven controls. For each bit it probes the first and last byte of every 16 KB slot under all four mode combinations. A long random phase then covers mixed register values, and addresses are biased toward the upper window.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
    localparam int ADDR_W     = 20;
    localparam int CFG_W      = 8;
    localparam int SLOT_AW    = 14;                 // 16 KB slot granule
    localparam int N_SLOTS    = 8;                  // slots in C0000-DFFFF
    localparam int SLOT_IW    = $clog2(N_SLOTS);
    localparam int RSVD_BIT   = 0;
    localparam int WIDE_BIT   = 1;                  // bit covering the 32 KB region
    localparam int WIDE_SLOTS = 2;                  // slots held by that bit
    localparam int RD_EN_BIT  = 7;
    localparam int WP_BIT     = 6;
    localparam logic [ADDR_W-1:0] WIN_BASE  = 20'hC0000;
    localparam logic [ADDR_W-1:0] BIOS_BASE = 20'hE0000;

    typedef enum logic [1:0] {
        AREA_NONE = 2'd0,
        AREA_SLOT = 2'd1,
        AREA_BIOS = 2'd2
    } area_e;

    typedef struct packed {
        area_e              area;
        logic [SLOT_IW-1:0] slot;
    } decode_t;

    typedef struct packed {
        logic dram;
        logic bus;
        logic dropped;
    } route_t;

    function automatic int slot_ctrl_bit(input int slot);
        return (slot < WIDE_SLOTS) ? WIDE_BIT : slot;
    endfunction

    function automatic route_t pick_route(input logic enabled, input logic is_wr,
                                          input logic rd_en, input logic wp);
        route_t r;
        r = '0;
        if (!enabled)   r.bus     = 1'b1;
        else if (is_wr) begin
            if (wp)     r.dropped = 1'b1;
            else        r.dram    = 1'b1;
        end
        else if (rd_en) r.dram    = 1'b1;
        else            r.bus     = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
    import shadow_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic         sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] seg_q,
    output logic [W-1:0] glb_q,
    output logic [W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q <= '0;
            glb_q <= '0;
        end else if (we) begin
            if (!sel) begin
                seg_q           <= wdata;
                seg_q[RSVD_BIT] <= 1'b0;
            end else begin
                glb_q <= wdata;
            end
        end
    end

    assign rdata = sel ? glb_q : seg_q;
endmodule

// File: rtl/shadow_region_decode.sv
module shadow_region_decode
    import shadow_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    always_comb begin
        dec      = '0;
        dec.area = AREA_NONE;
        if (addr >= BIOS_BASE) begin
            dec.area = AREA_BIOS;
        end else if (addr >= WIN_BASE) begin
            dec.area = AREA_SLOT;
            dec.slot = addr[SLOT_AW +: SLOT_IW];
        end
    end
endmodule

// File: rtl/shadow_route_logic.sv
module shadow_route_logic
    import shadow_pkg::*;
(
    input  decode_t    dec,
    input  logic [CFG_W-1:0] seg_q,
    input  logic [CFG_W-1:0] glb_q,
    input  logic       valid,
    input  logic       is_wr,
    output route_t     route
);
    logic [N_SLOTS-1:0] slot_en;

    genvar gi;
    generate
        for (gi = 0; gi < N_SLOTS; gi++) begin : g_slot
            localparam int CB = slot_ctrl_bit(gi);
            assign slot_en[gi] = seg_q[CB];
        end
    endgenerate

    logic enabled;
    always_comb begin
        unique case (dec.area)
            AREA_BIOS: enabled = 1'b1;
            AREA_SLOT: enabled = slot_en[dec.slot];
            default:   enabled = 1'b0;
        endcase
    end

    always_comb begin
        route = '0;
        if (valid && dec.area != AREA_NONE)
            route = pick_route(enabled, is_wr, glb_q[RD_EN_BIT], glb_q[WP_BIT]);
    end
endmodule

// File: rtl/shadow_route_ctrl.sv
module shadow_route_ctrl
    import shadow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    output logic              to_dram,
    output logic              to_bus,
    output logic              wr_dropped
);
    logic [CFG_W-1:0] seg_q;
    logic [CFG_W-1:0] glb_q;
    decode_t          dec;
    route_t           route;

    shadow_cfg_regs #(.W(CFG_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .seg_q (seg_q),
        .glb_q (glb_q),
        .rdata (cfg_rdata)
    );

    shadow_region_decode u_dec (
        .addr (acc_addr),
        .dec  (dec)
    );

    shadow_route_logic u_route (
        .dec   (dec),
        .seg_q (seg_q),
        .glb_q (glb_q),
        .valid (acc_valid),
        .is_wr (acc_write),
        .route (route)
    );

    assign to_dram    = route.dram;
    assign to_bus     = route.bus;
    assign wr_dropped = route.dropped;
endmodule

// File: rtl/shadow_route_chk.sv
module shadow_route_chk
    import shadow_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic              cfg_sel,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic [CFG_W-1:0]  cfg_rdata,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_write,
    input logic              to_dram,
    input logic              to_bus,
    input logic              wr_dropped,
    input logic [CFG_W-1:0]  seg_q,
    input logic [CFG_W-1:0]  glb_q
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (seg_q == '0 && glb_q == '0)); // R1

    AST_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_addr < WIN_BASE) |-> !(to_dram || to_bus || wr_dropped)); // R2

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cfg_sel |-> !cfg_rdata[RSVD_BIT]); // R3

    AST_WIDE_OFF_BUS: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_addr >= WIN_BASE && acc_addr < 20'hC8000 && !seg_q[WIDE_BIT])
        |-> (to_bus && !to_dram && !wr_dropped)); // R4

    AST_READ_NEEDS_RDEN: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && !glb_q[RD_EN_BIT]) |-> !to_dram); // R7

    AST_BIOS_WP_DROP: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_addr >= BIOS_BASE && glb_q[WP_BIT]) |-> wr_dropped); // R9

    AST_SEG_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_sel) |=> (seg_q[CFG_W-1:1] == $past(cfg_wdata[CFG_W-1:1]))); // R10

    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        $onehot0({to_dram, to_bus, wr_dropped})); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> !(to_dram || to_bus || wr_dropped)); // R11
endmodule

bind shadow_route_ctrl shadow_route_chk u_chk (.*);

// File: tb/shadow_route_ctrl_tb.sv
module shadow_route_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [19:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        to_dram, to_bus, wr_dropped;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_seg = '0;
    logic [7:0] m_glb = '0;

    always #5 clk = ~clk;

    shadow_route_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_write(acc_write), .to_dram(to_dram),
        .to_bus(to_bus), .wr_dropped(wr_dropped)
    );

    // returns {dram, bus, dropped}
    function automatic logic [2:0] exp_route(input logic [7:0] seg, input logic [7:0] glb,
                                             input logic [19:0] a, input logic wr);
        logic en;
        if (a < 20'hC0000) return 3'b000;
        if (a >= 20'hE0000)      en = 1'b1;
        else if (a < 20'hC8000)  en = seg[1];
        else                     en = seg[2 + int'((a - 20'hC8000) >> 14)];
        if (!en) return 3'b010;
        if (wr)  return glb[6] ? 3'b001 : 3'b100;
        return glb[7] ? 3'b100 : 3'b010;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) m_glb = d; else m_seg = {d[7:1], 1'b0};
    endtask

    task automatic access(input string req, input logic [19:0] a, input logic wr);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = wr;
        #1;
        check(req, {5'd0, to_dram, to_bus, wr_dropped}, {5'd0, exp_route(m_seg, m_glb, a, wr)});
        acc_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        cfg_sel = 1'b0; #1; check("R1 seg reset", cfg_rdata, 8'h00);
        cfg_sel = 1'b1; #1; check("R1 glb reset", cfg_rdata, 8'h00);
        access("R1 C0000 read", 20'hC0000, 1'b0);
        access("R1 DFFFF write", 20'hDFFFF, 1'b1);
        access("R1 F0000 read", 20'hF0000, 1'b0);
        access("R1 FFFFF write", 20'hFFFFF, 1'b1);
        // R3 reserved bit
        wr_reg(1'b0, 8'hFF);
        cfg_sel = 1'b0; #1; check("R3 seg readback", cfg_rdata, 8'hFE);
        wr_reg(1'b1, 8'h5B);
        cfg_sel = 1'b1; #1; check("R3 glb readback", cfg_rdata, 8'h5B);
        // R2 below window
        access("R2 BFFFF read", 20'hBFFFF, 1'b0);
        access("R2 00000 write", 20'h00000, 1'b1);
        // R11 idle
        @(negedge clk); acc_valid = 1'b0; acc_addr = 20'hE0000; #1;
        check("R11 idle quiet", {5'd0, to_dram, to_bus, wr_dropped}, 8'h00);
        // R10 next-cycle effect
        wr_reg(1'b0, 8'h00);
        wr_reg(1'b1, 8'h80);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 8'h02;
        acc_valid = 1'b1; acc_addr = 20'hC4000; acc_write = 1'b0;
        #1; check("R10 before edge", {5'd0, to_dram, to_bus, wr_dropped}, 8'h02);
        @(negedge clk);
        cfg_we = 1'b0; m_seg = 8'h02;
        #1; check("R10 after edge", {5'd0, to_dram, to_bus, wr_dropped}, 8'h04);
        acc_valid = 1'b0;
        // R4 R5 R6 R7 R8 R9 walk one enable bit
        for (int b = 1; b < 8; b++) begin
            wr_reg(1'b0, 8'(1 << b));
            for (int g = 0; g < 4; g++) begin
                wr_reg(1'b1, {g[1], g[0], 6'd0});
                for (int s = 0; s < 8; s++) begin
                    access("R4 R5 R6 slot start read", 20'hC0000 + 20'(s * 20'h4000), 1'b0);
                    access("R5 R8 slot end write", 20'hC3FFF + 20'(s * 20'h4000), 1'b1);
                end
                access("R9 BIOS read", 20'hE0000, 1'b0);
                access("R9 BIOS write", 20'hFFFFF, 1'b1);
            end
        end
        // R7 R8 R9 with segments off
        wr_reg(1'b0, 8'h00);
        wr_reg(1'b1, 8'hC0);
        access("R9 BIOS wp drop", 20'hE8000, 1'b1);
        access("R6 off write bus", 20'hD0000, 1'b1);
        // mixed random
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 4'd0) wr_reg(1'b0, 8'($urandom));
            else if (r[3:0] == 4'd1) wr_reg(1'b1, 8'($urandom));
            else access("R5 R7 R8 random", (r[5:4] == 2'b00) ? 20'($urandom) : {2'b11, 18'($urandom)}, r[8]);
        end
        finish_run();
    end
endmodule